// File: doc/BRIEF.md
# Dual-Output 9/7 Wavelet Analysis Filter

This block applies one level of the biorthogonal 9/7 wavelet analysis to a line of 8-bit pixels that arrive one per transfer. A single nine-entry window of recent samples feeds two multiply-accumulate trees side by side. The low-pass (approximation) and high-pass (detail) results of one position are therefore produced in the same cycle. Both outputs are decimated by two, so each line of N samples yields N/2 low/high pairs, presented together on one output strobe.

The line length is a run-time input, sampled with the first pixel of each line. At both ends of a line the missing neighbours are supplied by whole-sample mirror extension, so the edge pixel itself is not repeated. Input and output are valid/ready streams. A transfer takes place on a rising edge where both valid and ready are high. A source must hold valid and its data until the transfer. The output holds its pair until the sink accepts it. Output back-pressure stalls the input through `in_ready`.

Top module: `wavelet_pair_filter`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The low output for pair i is round(sum over k=-4..4 of h[|k|]*x[2i+k] / 4096), with h = {2470, 1093, -320, -69, 110} for |k| = 0..4. Rounding adds 2048 and then shifts right arithmetically by 12. The result is clamped to the signed 12-bit range [-2048, 2047] and presented two's complement on `out_low`.
- R3: The high output for pair i is centred on the odd sample 2i+1: round(sum over k=-3..3 of g[|k|]*x[2i+1+k] / 4096), with g = {4567, -2422, -236, 374}. It uses the same rounding and clamping as R2 and is presented on `out_high`.
- R4: Each line produces exactly N/2 pairs, in order of i. Pair i is not presented before sample min(2i+4, N-1) of its line has been accepted.
- R5: Indices below 0 are mirrored about sample 0: x[-k] = x[k].
- R6: Indices above N-1 are mirrored about the last sample: x[N-1+k] = x[N-1-k]. N is taken from `line_len` on the first accepted sample of each line. N must be even, from 6 to 2^LEN_W-2, and may differ from line to line.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_low` and `out_high` stay unchanged on the next cycle.
- R8: With `out_ready` held at 1, samples within a line are accepted on consecutive cycles. After the last sample of a line, `in_ready` is 0 for exactly the next two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_len | input | LEN_W | Samples per line, read with a line's first sample |
| in_valid | input | 1 | Input pixel is valid |
| in_ready | output | 1 | Block can take a pixel |
| in_pixel | input | PIX_W | Unsigned pixel sample |
| out_valid | output | 1 | Output pair is valid |
| out_ready | input | 1 | Sink takes the pair |
| out_low | output | OUT_W | Signed low-pass result |
| out_high | output | OUT_W | Signed high-pass result |

## Verification
The assertions assume that the source obeys the stream rules. Valid must be held with stable data until accepted, and `line_len` must be even and within range whenever a line's first pixel is offered. The position counts and the output range bounds both depend on these rules. The bench queues only even lengths from 6 up to the largest allowed. Its driver never drops valid or changes a pixel before the handshake, including when it inserts random gaps between pixels. Random output back-pressure is applied only on the sink side, which the block must tolerate in any pattern.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  localparam int COEF_FRAC = 12;
  localparam int COEF_W    = 14;
  localparam int WIN_TAPS  = 9;
  localparam int HP_TAPS   = 7;
  // symmetric halves, index = distance from the filter centre
  localparam int LP_COEF [5] = '{2470, 1093, -320, -69, 110};
  localparam int HP_COEF [4] = '{4567, -2422, -236, 374};

  typedef enum logic {PH_STREAM, PH_FLUSH} phase_e;
endpackage

// File: rtl/wpf_history.sv
module wpf_history #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         shift_en,
  input  logic [PIX_W-1:0]             din,
  output logic [DEPTH-1:0][PIX_W-1:0]  hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (shift_en) begin
      hist[0] <= din;
      for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
    end
  end
endmodule

// File: rtl/wpf_tap_select.sv
module wpf_tap_select #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 9,
  parameter int LEN_W = 11
) (
  input  logic [DEPTH-1:0][PIX_W-1:0] hist,
  input  logic [LEN_W-1:0]            centre,
  input  logic [LEN_W-1:0]            top_idx,
  input  logic [LEN_W-1:0]            len,
  output logic [DEPTH-1:0][PIX_W-1:0] win
);
  localparam int HALF  = (DEPTH - 1) / 2;
  localparam int IDX_W = $clog2(DEPTH);

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    int j;
    int m;
    int off;
    logic [IDX_W-1:0] sel;
    always_comb begin
      j = int'(centre) - HALF + k;
      if (j < 0)                    m = -j;
      else if (j > int'(len) - 1)   m = 2 * (int'(len) - 1) - j;
      else                          m = j;
      off = int'(top_idx) - m;
      sel = IDX_W'(off);
      win[k] = (off >= 0 && off < DEPTH) ? hist[sel] : '0;
    end
  end
endmodule

// File: rtl/wpf_mac_pair.sv
module wpf_mac_pair
  import wpf_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int OUT_W = 12
) (
  input  logic [WIN_TAPS-1:0][PIX_W-1:0] win,
  output logic signed [OUT_W-1:0]        low_res,
  output logic signed [OUT_W-1:0]        high_res
);
  localparam int HALF    = (WIN_TAPS - 1) / 2;
  localparam int HP_HALF = (HP_TAPS - 1) / 2;
  localparam int ACC_W   = PIX_W + COEF_W + 4;
  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((1 <<< (OUT_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] OUT_MIN = ACC_W'(-(1 <<< (OUT_W-1)));
  localparam int HALF_LSB = 1 <<< (COEF_FRAC - 1);

  logic signed [ACC_W-1:0] acc_lo, acc_hi, pre_lo, pre_hi;

  function automatic logic signed [OUT_W-1:0] shape(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] r;
    r = (a + ACC_W'(HALF_LSB)) >>> COEF_FRAC;
    if (r > OUT_MAX)      return OUT_W'(OUT_MAX);
    else if (r < OUT_MIN) return OUT_W'(OUT_MIN);
    else                  return OUT_W'(r);
  endfunction

  // low-pass tree: centre at window middle, symmetric pre-add
  always_comb begin
    acc_lo = '0;
    for (int t = 0; t <= HALF; t++) begin
      pre_lo = ACC_W'({1'b0, win[HALF - t]});
      if (t != 0) pre_lo = pre_lo + ACC_W'({1'b0, win[HALF + t]});
      acc_lo = acc_lo + ACC_W'(LP_COEF[t]) * pre_lo;
    end
  end

  // high-pass tree: centre one sample later in the same window
  always_comb begin
    acc_hi = '0;
    for (int t = 0; t <= HP_HALF; t++) begin
      pre_hi = ACC_W'({1'b0, win[HALF + 1 - t]});
      if (t != 0) pre_hi = pre_hi + ACC_W'({1'b0, win[HALF + 1 + t]});
      acc_hi = acc_hi + ACC_W'(HP_COEF[t]) * pre_hi;
    end
  end

  assign low_res  = shape(acc_lo);
  assign high_res = shape(acc_hi);
endmodule

// File: rtl/wpf_sequencer.sv
module wpf_sequencer
  import wpf_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [LEN_W-1:0] line_len,
  input  logic             slot_free,
  output logic             in_ready,
  output logic             accept,
  output logic             retire,
  output logic [LEN_W-1:0] req_c,
  output logic [LEN_W-1:0] req_p,
  output logic [LEN_W-1:0] req_n
);
  localparam int HALF = (WIN_TAPS - 1) / 2;

  phase_e           phase;
  logic [LEN_W-1:0] cnt, len_q, len_cur;
  logic             req_v, flush_step;

  assign retire   = req_v && slot_free;
  assign in_ready = (phase == PH_STREAM) && (!req_v || retire);
  assign accept   = in_valid && in_ready;
  assign len_cur  = (cnt == '0) ? line_len : len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_STREAM;
      cnt        <= '0;
      len_q      <= '0;
      req_v      <= 1'b0;
      flush_step <= 1'b0;
      req_c      <= '0;
      req_p      <= '0;
      req_n      <= '0;
    end else begin
      if (retire) req_v <= 1'b0;
      if (accept) begin
        if (cnt == '0) len_q <= line_len;
        if (cnt == len_cur - LEN_W'(1)) begin
          phase      <= PH_FLUSH;
          flush_step <= 1'b0;
        end
        cnt <= cnt + LEN_W'(1);
        if (!cnt[0] && cnt >= LEN_W'(HALF)) begin
          req_v <= 1'b1;
          req_c <= cnt - LEN_W'(HALF);
          req_p <= cnt;
          req_n <= len_cur;
        end
      end else if (phase == PH_FLUSH && (!req_v || retire)) begin
        req_v <= 1'b1;
        req_p <= len_q - LEN_W'(1);
        req_n <= len_q;
        if (flush_step) begin
          req_c <= len_q - LEN_W'(2);
          phase <= PH_STREAM;
          cnt   <= '0;
        end else begin
          req_c      <= len_q - LEN_W'(HALF);
          flush_step <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wavelet_pair_filter.sv
module wavelet_pair_filter
  import wpf_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int OUT_W = 12,
  parameter int LEN_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LEN_W-1:0]        line_len,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PIX_W-1:0]        in_pixel,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_low,
  output logic signed [OUT_W-1:0] out_high
);
  logic                              accept, retire, slot_free;
  logic [LEN_W-1:0]                  req_c, req_p, req_n;
  logic [WIN_TAPS-1:0][PIX_W-1:0]    hist, win;
  logic signed [OUT_W-1:0]           low_res, high_res;

  assign slot_free = !out_valid || out_ready;

  wpf_sequencer #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .line_len(line_len),
    .slot_free(slot_free), .in_ready(in_ready), .accept(accept),
    .retire(retire), .req_c(req_c), .req_p(req_p), .req_n(req_n)
  );

  wpf_history #(.PIX_W(PIX_W), .DEPTH(WIN_TAPS)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(in_pixel), .hist(hist)
  );

  wpf_tap_select #(.PIX_W(PIX_W), .DEPTH(WIN_TAPS), .LEN_W(LEN_W)) u_sel (
    .hist(hist), .centre(req_c), .top_idx(req_p), .len(req_n), .win(win)
  );

  wpf_mac_pair #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_mac (
    .win(win), .low_res(low_res), .high_res(high_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_low   <= '0;
      out_high  <= '0;
    end else if (retire) begin
      out_valid <= 1'b1;
      out_low   <= low_res;
      out_high  <= high_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wpf_checker.sv
module wpf_checker #(
  parameter int PIX_W = 8,
  parameter int OUT_W = 12,
  parameter int LEN_W = 11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LEN_W-1:0]        line_len,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_low,
  input logic signed [OUT_W-1:0] out_high
);
  localparam int PMAX   = (1 << PIX_W) - 1;
  localparam int LO_POS = 2470 + 2 * 1093 + 2 * 110;
  localparam int LO_NEG = 2 * 320 + 2 * 69;
  localparam int HI_ABS = 4567 + 2 * 374;
  localparam int HI_NAB = 2 * 2422 + 2 * 236;
  localparam int LO_MAX = (PMAX * LO_POS) / 4096 + 1;
  localparam int LO_MIN = -((PMAX * LO_NEG) / 4096 + 1);
  localparam int HI_MAX = (PMAX * HI_ABS) / 4096 + 1;
  localparam int HI_MIN = -((PMAX * HI_NAB) / 4096 + 1);

  int unsigned in_total, out_total;
  logic [LEN_W-1:0] pos, llen, leff;
  logic take_in, take_out, last_in;

  assign take_in  = in_valid && in_ready;
  assign take_out = out_valid && out_ready;
  assign leff     = (pos == '0) ? line_len : llen;
  assign last_in  = take_in && (pos == leff - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_total <= 0; out_total <= 0; pos <= '0; llen <= '0;
    end else begin
      if (take_in) in_total <= in_total + 1;
      if (take_out) out_total <= out_total + 1;
      if (take_in) begin
        if (pos == '0) llen <= line_len;
        pos <= last_in ? '0 : pos + LEN_W'(1);
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_low) && $stable(out_high)); // R7
  AST_NO_EARLY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    take_out |-> (2 * out_total + 2 <= in_total)); // R4
  AST_FLUSH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    last_in |=> !in_ready); // R8
  AST_LOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_low) <= LO_MAX && int'(out_low) >= LO_MIN)); // R2
  AST_HIGH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_high) <= HI_MAX && int'(out_high) >= HI_MIN)); // R3
endmodule

bind wavelet_pair_filter wpf_checker #(.PIX_W(PIX_W), .OUT_W(OUT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_len(line_len), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_low(out_low), .out_high(out_high)
);

// File: tb/test_wavelet_pair_filter.sv
`timescale 1ns/1ps
module test_wavelet_pair_filter;
  localparam int PIX_W = 8;
  localparam int OUT_W = 12;
  localparam int LEN_W = 11;
  localparam int LP [5] = '{2470, 1093, -320, -69, 110};
  localparam int HP [4] = '{4567, -2422, -236, 374};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LEN_W-1:0] line_len = '0;
  logic in_valid = 1'b0, in_ready;
  logic [PIX_W-1:0] in_pixel = '0;
  logic out_valid, out_ready = 1'b0;
  logic signed [OUT_W-1:0] out_low, out_high;

  always #2 clk = ~clk;

  wavelet_pair_filter #(.PIX_W(PIX_W), .OUT_W(OUT_W), .LEN_W(LEN_W)) i_wavelet_pair_filter (
    .clk(clk), .rst_n(rst_n), .line_len(line_len), .in_valid(in_valid),
    .in_ready(in_ready), .in_pixel(in_pixel), .out_valid(out_valid),
    .out_ready(out_ready), .out_low(out_low), .out_high(out_high)
  );

  int n_checks = 0, n_fail = 0, cycles = 0, stall_cnt = 0, pairs_seen = 0, pairs_exp = 0;
  bit timed_out = 0, gap_mode = 0, bp_mode = 0, took_in = 0, held = 0;
  int held_lo, held_hi;
  int pix_q[$], len_q[$], exp_lo[$], exp_hi[$];
  string tag_lo[$], tag_hi[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int mir(int j, int n);
    if (j < 0) return -j;
    if (j > n - 1) return 2 * (n - 1) - j;
    return j;
  endfunction

  function automatic int shape(int acc);
    int r = (acc + 2048) >>> 12;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  task automatic add_line(int n, int kind);
    int x[];
    x = new[n];
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: x[i] = (i * 37 + 11) % 256;
        1: x[i] = $urandom_range(255);
        2: x[i] = (i % 2) ? 255 : 0;
        3: x[i] = 200;
        4: x[i] = (i == 0) ? 255 : 0;
        default: x[i] = (i == n - 1) ? 255 : 0;
      endcase
      pix_q.push_back(x[i]);
      len_q.push_back(n);
    end
    for (int i = 0; i < n / 2; i++) begin
      int lo = 0, hi = 0;
      for (int k = -4; k <= 4; k++) lo += LP[k < 0 ? -k : k] * x[mir(2 * i + k, n)];
      for (int k = -3; k <= 3; k++) hi += HP[k < 0 ? -k : k] * x[mir(2 * i + 1 + k, n)];
      exp_lo.push_back(shape(lo));
      exp_hi.push_back(shape(hi));
      tag_lo.push_back(i == 0 ? "R5" : (i >= n / 2 - 2 ? "R6" : "R2"));
      tag_hi.push_back(i == 0 ? "R5" : (i >= n / 2 - 2 ? "R6" : "R3"));
      pairs_exp++;
    end
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    if (cycles > 150000 && !timed_out) begin
      timed_out = 1;
      check(0, "R4", "watchdog expired", cycles, 150000);
    end
    if (!(in_valid && !took_in)) begin
      in_valid = (pix_q.size() > 0) && (!gap_mode || $urandom_range(3) != 0);
      if (pix_q.size() > 0) begin
        in_pixel = PIX_W'(pix_q[0]);
        line_len = LEN_W'(len_q[0]);
      end
    end
    out_ready = !bp_mode || ($urandom_range(2) != 0);
    #1;
    if (held) begin
      check(out_valid && int'(out_low) == held_lo && int'(out_high) == held_hi,
            "R7", "pair held under back-pressure", int'(out_low), held_lo);
    end
    held = out_valid && !out_ready;
    held_lo = int'(out_low);
    held_hi = int'(out_high);
    took_in = in_valid && in_ready;
    if (took_in) begin
      void'(pix_q.pop_front());
      void'(len_q.pop_front());
    end
    if (in_valid && !in_ready) stall_cnt++;
    if (out_valid && out_ready) begin
      pairs_seen++;
      if (exp_lo.size() == 0) begin
        check(0, "R4", "unexpected extra pair", pairs_seen, pairs_exp);
      end else begin
        check(int'(out_low) == exp_lo[0], tag_lo[0], "low output", int'(out_low), exp_lo[0]);
        check(int'(out_high) == exp_hi[0], tag_hi[0], "high output", int'(out_high), exp_hi[0]);
        void'(exp_lo.pop_front()); void'(exp_hi.pop_front());
        void'(tag_lo.pop_front()); void'(tag_hi.pop_front());
      end
    end
  endtask

  task automatic drain();
    while ((pix_q.size() > 0 || exp_lo.size() > 0) && !timed_out) step();
    repeat (4) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // full rate, three lines back to back: R8 gap count
    add_line(6, 0);
    add_line(8, 1);
    add_line(16, 2);
    stall_cnt = 0;
    drain();
    check(stall_cnt == 4, "R8", "in_ready low cycles between three lines", stall_cnt, 4);

    // random input gaps and output back-pressure, boundary patterns
    gap_mode = 1;
    bp_mode = 1;
    add_line(10, 5);
    add_line(12, 4);
    add_line(32, 1);
    add_line(6, 3);
    add_line(6, 5);
    add_line(2046, 1);
    add_line(8, 2);
    drain();

    check(pairs_seen == pairs_exp, "R4", "total pairs emitted", pairs_seen, pairs_exp);
    check(exp_lo.size() == 0, "R4", "pairs still missing", exp_lo.size(), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule